// File: doc/BRIEF.md
# Tamper Detection Zeroization Controller

This block watches a set of cover-separation switches mounted in parallel around an enclosure, together with a manual emergency-erase button. Each raw input is brought into the clock domain through a two-flop synchronizer. It is then debounced by a run-length filter whose threshold is set at an input port. When any filtered source becomes active, the block latches an alarm interrupt for the controlling processor. It also emits a single-cycle hardware zeroize strobe and starts a sequential wipe of a small on-chip register file that holds critical parameters.

The wipe writes zero into every word of the key store in ascending order. It then reads every word back and ends in a sticky "cleared" or "fault" result. From the alarm edge onward, the read port of the key store returns zero whatever its contents. A sticky cause register records every source that has fired since reset. A two-bit status code drives the module LEDs. Before any alarm, the processor writes and reads the key store through a plain synchronous port.

Top module: `tamper_zeroize_ctrl`

## Requirements
- R1: After a synchronous reset, alarm_irq_o, zeroize_o, wipe_done_o and wipe_error_o are 0, cause_o is all zero and led_code_o is 2'b00.
- R2: Let D = debounce_cfg_i, with the value 0 taken as 1. A source sampled high at fewer than D consecutive rising edges is ignored. A source held high raises alarm_irq_o on the (D+3)-th rising edge, counting the first edge at which it is sampled high as edge 1.
- R3: Any single cover input (cover_sep_i bit high = separated) or the button (zero_btn_i high = pressed) is enough to raise the alarm. The sources are ORed.
- R4: Once raised, alarm_irq_o stays high until reset, even after every input returns low.
- R5: cause_o bit i (i < NUM_COVER) records cover i and bit NUM_COVER records the button. Bits are set on the edge at which the source passes its filter. They are never cleared except by reset, and sources that fire after the alarm are still added.
- R6: zeroize_o is a one-cycle pulse on the same edge that alarm_irq_o rises. It occurs at most once per reset.
- R7: The wipe spends KEY_WORDS cycles writing zero and then KEY_WORDS cycles reading back. wipe_done_o rises 2*KEY_WORDS edges after the alarm edge if every word read back as zero, otherwise wipe_error_o rises. Both results are sticky and never high together.
- R8: key_rd_data_o is zero on the alarm edge and on every later cycle.
- R9: led_code_o is 2'b00 when armed, 2'b01 while the wipe runs, 2'b10 after a clean wipe, and 2'b11 after a failed read-back.
- R10: Before the alarm, a write with key_wr_en_i high stores key_wr_data_i at key_wr_addr_i. The same address then reads back that value combinationally on key_rd_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cover_sep_i | input | NUM_COVER | Raw cover-separation switches, 1 = separated |
| zero_btn_i | input | 1 | Raw emergency-erase button, 1 = pressed |
| debounce_cfg_i | input | CNT_W | Required stable cycles per input (0 acts as 1) |
| key_wr_en_i | input | 1 | Key store write enable |
| key_wr_addr_i | input | ADDR_W | Key store write address |
| key_wr_data_i | input | DATA_W | Key store write data |
| key_rd_addr_i | input | ADDR_W | Key store read address |
| key_rd_data_o | output | DATA_W | Key store read data, forced to zero after alarm |
| alarm_irq_o | output | 1 | Latched alarm interrupt |
| zeroize_o | output | 1 | Single-cycle zeroize strobe |
| wipe_done_o | output | 1 | Sticky: wipe verified clean |
| wipe_error_o | output | 1 | Sticky: wipe read-back found a nonzero word |
| cause_o | output | NUM_COVER+1 | Sticky cause bits, covers low, button at the top |
| led_code_o | output | 2 | Status LED code |

## Verification
A wrong debounce count shows as an alarm that arrives one or more edges away from D+3. It also shows as a short pulse that wrongly raises the alarm. A wipe sequencer that skips or repeats a step shifts wipe_done_o away from 32 edges after the alarm. A stuck or dropped word leaves the sequencer in the fault state, which shows on wipe_error_o and the LED code at that same point. A cause or alarm latch that forgets its state shows at the next cycle, because both registers stay observable at the ports for the rest of the run.

// File: rtl/tzc_pkg.sv
package tzc_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_CLEAR,
        WS_VERIFY,
        WS_DONE,
        WS_FAIL
    } wipe_state_e;

    typedef enum logic [1:0] {
        LED_ARMED   = 2'b00,
        LED_WIPING  = 2'b01,
        LED_CLEARED = 2'b10,
        LED_FAULT   = 2'b11
    } led_code_e;

    function automatic led_code_e led_from_status(
        input logic busy,
        input logic done,
        input logic fault
    );
        if (fault)
            return LED_FAULT;
        else if (done)
            return LED_CLEARED;
        else if (busy)
            return LED_WIPING;
        return LED_ARMED;
    endfunction

endpackage

// File: rtl/tzc_input_filter.sv
module tzc_input_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o
);
    logic             meta_q;
    logic             sync_q;
    logic             level_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_next;
    logic [CNT_W:0]   need;

    assign run_next = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};
    assign need     = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            level_q <= 1'b0;
            run_q   <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q != level_q) begin
                if (run_next >= need) begin
                    level_q <= sync_q;
                    run_q   <= '0;
                end else begin
                    run_q <= run_next[CNT_W-1:0];
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/tzc_key_store.sv
module tzc_key_store #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [ADDR_W-1:0] vaddr_i,
    output logic [DATA_W-1:0] vdata_o
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we_i)
            cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
    assign vdata_o = cells[vaddr_i];
endmodule

// File: rtl/tzc_wipe_seq.sv
module tzc_wipe_seq
    import tzc_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              clr_we_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [DATA_W-1:0] vdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

    wipe_state_e       state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              bad_q;
    logic              bad_now;

    assign bad_now = bad_q | (vdata_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            ptr_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (start_i) begin
                        state_q <= WS_CLEAR;
                        ptr_q   <= '0;
                        bad_q   <= 1'b0;
                    end
                end
                WS_CLEAR: begin
                    if (ptr_q == LAST) begin
                        state_q <= WS_VERIFY;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                WS_VERIFY: begin
                    bad_q <= bad_now;
                    if (ptr_q == LAST) begin
                        state_q <= bad_now ? WS_FAIL : WS_DONE;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                WS_DONE: state_q <= WS_DONE;
                WS_FAIL: state_q <= WS_FAIL;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    assign clr_we_o = (state_q == WS_CLEAR);
    assign addr_o   = ptr_q;
    assign busy_o   = (state_q == WS_CLEAR) || (state_q == WS_VERIFY);
    assign done_o   = (state_q == WS_DONE);
    assign fault_o  = (state_q == WS_FAIL);
endmodule

// File: rtl/tamper_zeroize_ctrl.sv
module tamper_zeroize_ctrl
    import tzc_pkg::*;
#(
    parameter int NUM_COVER = 3,
    parameter int CNT_W     = 8,
    parameter int KEY_WORDS = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(KEY_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_COVER-1:0] cover_sep_i,
    input  logic                 zero_btn_i,
    input  logic [CNT_W-1:0]     debounce_cfg_i,
    input  logic                 key_wr_en_i,
    input  logic [ADDR_W-1:0]    key_wr_addr_i,
    input  logic [DATA_W-1:0]    key_wr_data_i,
    input  logic [ADDR_W-1:0]    key_rd_addr_i,
    output logic [DATA_W-1:0]    key_rd_data_o,
    output logic                 alarm_irq_o,
    output logic                 zeroize_o,
    output logic                 wipe_done_o,
    output logic                 wipe_error_o,
    output logic [NUM_COVER:0]   cause_o,
    output logic [1:0]           led_code_o
);
    localparam int NSRC = NUM_COVER + 1;

    logic [NSRC-1:0]   raw_src;
    logic [NSRC-1:0]   level;
    logic              trig;
    logic              fire;
    logic              alarm_q;
    logic              strobe_q;
    logic [NSRC-1:0]   cause_q;

    logic              wipe_we;
    logic [ADDR_W-1:0] wipe_addr;
    logic [DATA_W-1:0] vdata;
    logic              wipe_busy;
    logic              wipe_done;
    logic              wipe_fault;

    logic              ks_we;
    logic [ADDR_W-1:0] ks_waddr;
    logic [DATA_W-1:0] ks_wdata;
    logic [DATA_W-1:0] ks_rdata;

    assign raw_src = {zero_btn_i, cover_sep_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        tzc_input_filter #(.CNT_W(CNT_W)) filt_i (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_src[s]),
            .limit_i (debounce_cfg_i),
            .level_o (level[s])
        );
    end

    assign trig = |level;
    assign fire = trig & ~alarm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= 1'b0;
            strobe_q <= 1'b0;
            cause_q  <= '0;
        end else begin
            alarm_q  <= alarm_q | trig;
            strobe_q <= fire;
            cause_q  <= cause_q | level;
        end
    end

    tzc_wipe_seq #(
        .WORDS  (KEY_WORDS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (fire),
        .clr_we_o (wipe_we),
        .addr_o   (wipe_addr),
        .vdata_i  (vdata),
        .busy_o   (wipe_busy),
        .done_o   (wipe_done),
        .fault_o  (wipe_fault)
    );

    assign ks_we    = wipe_we | (key_wr_en_i & ~alarm_q);
    assign ks_waddr = wipe_we ? wipe_addr : key_wr_addr_i;
    assign ks_wdata = wipe_we ? '0 : key_wr_data_i;

    tzc_key_store #(
        .WORDS  (KEY_WORDS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) store_i (
        .clk     (clk),
        .we_i    (ks_we),
        .waddr_i (ks_waddr),
        .wdata_i (ks_wdata),
        .raddr_i (key_rd_addr_i),
        .rdata_o (ks_rdata),
        .vaddr_i (wipe_addr),
        .vdata_o (vdata)
    );

    assign key_rd_data_o = alarm_q ? '0 : ks_rdata;
    assign alarm_irq_o   = alarm_q;
    assign zeroize_o     = strobe_q;
    assign wipe_done_o   = wipe_done;
    assign wipe_error_o  = wipe_fault;
    assign cause_o       = cause_q;
    assign led_code_o    = led_from_status(wipe_busy, wipe_done, wipe_fault);
endmodule

// File: rtl/tzc_checker.sv
module tzc_checker #(
    parameter int NUM_COVER = 3,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              alarm_irq_o,
    input logic              zeroize_o,
    input logic              wipe_done_o,
    input logic              wipe_error_o,
    input logic [NUM_COVER:0] cause_o,
    input logic [DATA_W-1:0] key_rd_data_o,
    input logic [1:0]        led_code_o
);
    // R4
    alarm_latch_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq_o |=> alarm_irq_o);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        zeroize_o |=> !zeroize_o);

    // R6
    strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
        zeroize_o == $rose(alarm_irq_o));

    // R5
    cause_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_o != '0) == alarm_irq_o);

    // R5
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq_o |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    // R8
    wiped_read_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq_o |-> (key_rd_data_o == '0));

    // R7
    result_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wipe_done_o && wipe_error_o));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_done_o |=> wipe_done_o);

    // R9
    led_done_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_done_o |-> (led_code_o == 2'b10));
endmodule

bind tamper_zeroize_ctrl tzc_checker #(
    .NUM_COVER (NUM_COVER),
    .DATA_W    (DATA_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .alarm_irq_o   (alarm_irq_o),
    .zeroize_o     (zeroize_o),
    .wipe_done_o   (wipe_done_o),
    .wipe_error_o  (wipe_error_o),
    .cause_o       (cause_o),
    .key_rd_data_o (key_rd_data_o),
    .led_code_o    (led_code_o)
);

// File: tb/tamper_zeroize_ctrl_tb_top.sv
module tamper_zeroize_ctrl_tb_top;
    localparam int NUM_COVER = 3;
    localparam int CNT_W     = 8;
    localparam int KEY_WORDS = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = $clog2(KEY_WORDS);
    localparam int NVEC      = 8;

    typedef struct packed {
        logic [3:0] src;
        logic [7:0] hold;
        logic [7:0] dbc;
        logic       exp_alarm;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 8'd5,  8'd4,  1'b1},
        '{4'b0010, 8'd3,  8'd4,  1'b0},
        '{4'b0100, 8'd8,  8'd8,  1'b1},
        '{4'b1000, 8'd2,  8'd2,  1'b1},
        '{4'b1000, 8'd1,  8'd2,  1'b0},
        '{4'b0101, 8'd6,  8'd3,  1'b1},
        '{4'b0010, 8'd1,  8'd0,  1'b1},
        '{4'b1111, 8'd10, 8'd16, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_COVER-1:0] cover_sep_i = '0;
    logic                 zero_btn_i = 1'b0;
    logic [CNT_W-1:0]     debounce_cfg_i = '0;
    logic                 key_wr_en_i = 1'b0;
    logic [ADDR_W-1:0]    key_wr_addr_i = '0;
    logic [DATA_W-1:0]    key_wr_data_i = '0;
    logic [ADDR_W-1:0]    key_rd_addr_i = '0;
    logic [DATA_W-1:0]    key_rd_data_o;
    logic                 alarm_irq_o;
    logic                 zeroize_o;
    logic                 wipe_done_o;
    logic                 wipe_error_o;
    logic [NUM_COVER:0]   cause_o;
    logic [1:0]           led_code_o;

    int n_chk = 0;
    int n_bad = 0;
    int zpulses = 0;

    always #4 clk = ~clk;

    tamper_zeroize_ctrl #(
        .NUM_COVER (NUM_COVER),
        .CNT_W     (CNT_W),
        .KEY_WORDS (KEY_WORDS),
        .DATA_W    (DATA_W)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .cover_sep_i    (cover_sep_i),
        .zero_btn_i     (zero_btn_i),
        .debounce_cfg_i (debounce_cfg_i),
        .key_wr_en_i    (key_wr_en_i),
        .key_wr_addr_i  (key_wr_addr_i),
        .key_wr_data_i  (key_wr_data_i),
        .key_rd_addr_i  (key_rd_addr_i),
        .key_rd_data_o  (key_rd_data_o),
        .alarm_irq_o    (alarm_irq_o),
        .zeroize_o      (zeroize_o),
        .wipe_done_o    (wipe_done_o),
        .wipe_error_o   (wipe_error_o),
        .cause_o        (cause_o),
        .led_code_o     (led_code_o)
    );

    always @(posedge clk) begin
        if (rst)
            zpulses = 0;
        else if (zeroize_o)
            zpulses = zpulses + 1;
    end

    function automatic logic [DATA_W-1:0] key_pat(input int i);
        return 32'hC0DE_0000 + (i * 32'h0101) + 1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cover_sep_i = '0;
        zero_btn_i = 1'b0;
        key_wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fill_keys();
        for (int i = 0; i < KEY_WORDS; i++) begin
            key_wr_en_i   = 1'b1;
            key_wr_addr_i = ADDR_W'(i);
            key_wr_data_i = key_pat(i);
            @(negedge clk);
        end
        key_wr_en_i = 1'b0;
    endtask

    task automatic keys_match(input logic wiped, output int mism);
        mism = 0;
        for (int i = 0; i < KEY_WORDS; i++) begin
            key_rd_addr_i = ADDR_W'(i);
            #1;
            if (key_rd_data_o !== (wiped ? '0 : key_pat(i)))
                mism++;
        end
    endtask

    task automatic drive_src(input logic [3:0] s);
        cover_sep_i = s[NUM_COVER-1:0];
        zero_btn_i  = s[3];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int mism;
        int n;

        // R1: reset state
        do_reset();
        check("R1", "alarm", 32'(alarm_irq_o), 32'd0);
        check("R1", "zeroize", 32'(zeroize_o), 32'd0);
        check("R1", "cause", 32'(cause_o), 32'd0);
        check("R1", "led", 32'(led_code_o), 32'd0);
        check("R1", "done/error", {30'd0, wipe_done_o, wipe_error_o}, 32'd0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            logic exp_a;
            do_reset();
            debounce_cfg_i = VECS[v].dbc;
            fill_keys();
            drive_src(VECS[v].src);
            repeat (int'(VECS[v].hold)) @(negedge clk);
            drive_src(4'b0000);
            repeat (60) @(negedge clk);
            exp_a = VECS[v].exp_alarm;
            check("R2/R3/R4", $sformatf("vec%0d alarm", v), 32'(alarm_irq_o), 32'(exp_a));
            check("R5", $sformatf("vec%0d cause", v), 32'(cause_o),
                  exp_a ? 32'(VECS[v].src) : 32'd0);
            check("R6", $sformatf("vec%0d strobes", v), 32'(zpulses), exp_a ? 32'd1 : 32'd0);
            check("R7", $sformatf("vec%0d done", v), 32'(wipe_done_o), 32'(exp_a));
            check("R7", $sformatf("vec%0d error", v), 32'(wipe_error_o), 32'd0);
            check("R9", $sformatf("vec%0d led", v), 32'(led_code_o), exp_a ? 32'd2 : 32'd0);
            keys_match(exp_a, mism);
            check(exp_a ? "R8" : "R10", $sformatf("vec%0d key words", v), 32'(mism), 32'd0);
        end

        // R2: exact latency with D = 4 gives D+3 = 7 edges
        do_reset();
        debounce_cfg_i = 8'd4;
        fill_keys();
        key_rd_addr_i = ADDR_W'(5);
        cover_sep_i = 3'b010;
        n = 0;
        while (!alarm_irq_o && n < 50) begin
            @(negedge clk);
            n++;
        end
        cover_sep_i = '0;
        check("R2", "alarm latency", 32'(n), 32'd7);
        check("R6", "strobe on alarm edge", 32'(zeroize_o), 32'd1);
        check("R9", "led while wiping", 32'(led_code_o), 32'd1);
        #1;
        check("R8", "read zero at alarm edge", key_rd_data_o, 32'd0);
        n = 0;
        @(negedge clk);
        n++;
        check("R6", "strobe one cycle", 32'(zeroize_o), 32'd0);
        while (!wipe_done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R7", "wipe duration", 32'(n), 32'(2 * KEY_WORDS));

        // R5: button after alarm adds cause, no second strobe
        zero_btn_i = 1'b1;
        repeat (10) @(negedge clk);
        zero_btn_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R5", "accumulated cause", 32'(cause_o), 32'b1010);
        check("R6", "single strobe per reset", 32'(zpulses), 32'd1);
        check("R4", "alarm held after release", 32'(alarm_irq_o), 32'd1);
        check("R7", "done sticky", 32'(wipe_done_o), 32'd1);

        // R10: plain write/read before alarm
        do_reset();
        key_wr_en_i = 1'b1;
        key_wr_addr_i = ADDR_W'(9);
        key_wr_data_i = 32'h1357_9BDF;
        @(negedge clk);
        key_wr_en_i = 1'b0;
        key_rd_addr_i = ADDR_W'(9);
        #1;
        check("R10", "write then read", key_rd_data_o, 32'h1357_9BDF);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule